// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Status Flags

This block adds or subtracts two signed two's-complement operands in one combinational pass. When the true result does not fit in the operand width, it clamps the result to the largest positive value or the most negative value. The clamped result appears at the output in the same cycle as the operands. A registered status word holds four flags: zero, sign, carry and overflow. All four are rewritten on every clock edge where the operation strobe is high. The zero and sign flags come from the clamped value, not from the wrapped sum.

A fifth status bit records that saturation has happened at least once. Operations can set it but never clear it. Only an explicit synchronous clear input returns it to zero. Callers with immediate operands sign-extend them to full width before presenting them.

Top module: `sat_addsub_core`

## Requirements
- R1: With no overflow, `sum_out` equals `opnd_a + opnd_b` (when `op_sub` = 0) or `opnd_a - opnd_b` (when `op_sub` = 1), taken modulo 2^WIDTH.
- R2: Overflow is detected under these conditions:
  - For addition, the operand sign bits are equal and the wrapped result's sign differs from `opnd_a`'s sign.
  - For subtraction, the operand sign bits differ and the wrapped result's sign differs from `opnd_a`'s sign.
  - The registered `flag_v` takes this value.
- R3: On overflow with a negative wrapped result, `sum_out` is the largest positive value (MSB 0, all other bits 1). The registered sign and zero flags are both 0.
- R4: On overflow with a non-negative wrapped result, `sum_out` is the most negative value (MSB 1, all other bits 0). The sign flag is 1 and the zero flag is 0, even if the wrapped result was zero.
- R5: After an operation, `flag_z` is 1 exactly when the clamped `sum_out` of that operation was all zeros. `flag_s` equals its MSB.
- R6: For addition, `flag_c` is the carry out of the unsigned WIDTH-bit sum.
- R7: For subtraction, `flag_c` is 1 exactly when `opnd_a` is smaller than `opnd_b` as unsigned values (a borrow).
- R8: `flag_z`, `flag_s`, `flag_c` and `flag_v` update on the rising clock edge when `op_valid` is 1. They hold their values when `op_valid` is 0, whatever the operands are.
- R9: `flag_sat` is set on any edge where `op_valid` is 1 and the operation overflows. An operation without overflow leaves it unchanged.
- R10: `sat_clear` = 1 clears `flag_sat` at the next rising edge. If an overflowing operation arrives on the same edge, the set takes priority and `flag_sat` ends at 1.
- R11: While `rst_n` is 0, all five status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Strobe: latch status of the current operation |
| op_sub | input | 1 | 0 = add, 1 = subtract (a - b) |
| opnd_a | input | WIDTH | First operand / minuend |
| opnd_b | input | WIDTH | Second operand / subtrahend |
| sat_clear | input | 1 | Synchronous clear of the sticky saturation bit |
| sum_out | output | WIDTH | Clamped result, combinational |
| flag_z | output | 1 | Registered zero flag |
| flag_s | output | 1 | Registered sign flag |
| flag_c | output | 1 | Registered carry / borrow flag |
| flag_v | output | 1 | Registered overflow flag |
| flag_sat | output | 1 | Sticky saturation flag |

## Verification
The bench builds one instance with WIDTH = 4. At that width every operand pair in both add and subtract modes can be swept, which is 512 operations. This covers both clamp directions, borrow and carry at every boundary, and the case where the wrapped sum is zero but the clamped value is the most negative number. A second instance at the default WIDTH = 32 gets directed cases at the signed extremes. During the sweep, clears are interleaved with overflowing operations. This exercises the sticky bit in both orders and the same-edge priority.

// File: rtl/satarith_pkg.sv
package satarith_pkg;

    // Four flags rewritten by every accepted operation
    typedef struct packed {
        logic zero;
        logic sign;
        logic carry;
        logic ovf;
    } alu_flags_t;

    // Full registered status word
    typedef struct packed {
        alu_flags_t flags;
        logic       sticky;
    } status_t;

    localparam status_t STATUS_RESET = '0;

endpackage

// File: rtl/sat_raw_adder.sv
module sat_raw_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] raw_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   ext_sum;

    always_comb begin
        // Subtraction as a + ~b + 1
        b_eff   = sub_i ? ~b_i : b_i;
        ext_sum = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
        raw_o   = ext_sum[MSB:0];
        // Carry out for add; inverted carry is the borrow for subtract
        carry_o = sub_i ? ~ext_sum[WIDTH] : ext_sum[WIDTH];
        // Effective operands share a sign while the result flips away from it
        ovf_o   = (a_i[MSB] == b_eff[MSB]) && (raw_o[MSB] != a_i[MSB]);
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] raw_i,
    input  logic             ovf_i,
    output logic [WIDTH-1:0] res_o,
    output logic             zero_o,
    output logic             sign_o
);
    localparam int               MSB     = WIDTH - 1;
    localparam logic [WIDTH-1:0] POS_MAX = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] NEG_MIN = {1'b1, {(WIDTH-1){1'b0}}};

    always_comb begin
        if (ovf_i && raw_i[MSB]) begin
            // Wrapped negative: true value ran past the top
            res_o = POS_MAX;
        end else if (ovf_i) begin
            // Wrapped non-negative: true value ran past the bottom
            res_o = NEG_MIN;
        end else begin
            res_o = raw_i;
        end
        zero_o = (res_o == '0);
        sign_o = res_o[MSB];
    end
endmodule

// File: rtl/sat_status_reg.sv
module sat_status_reg
    import satarith_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_i,
    input  logic       clr_i,
    input  alu_flags_t flags_i,
    output status_t    status_o
);
    status_t status_d, status_q;

    always_comb begin
        status_d = status_q;
        if (clr_i) begin
            status_d.sticky = 1'b0;
        end
        if (upd_i) begin
            status_d.flags = flags_i;
            // Setting after clearing gives the set priority on the same edge
            if (flags_i.ovf) begin
                status_d.sticky = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= STATUS_RESET;
        end else begin
            status_q <= status_d;
        end
    end

    assign status_o = status_q;
endmodule

// File: rtl/sat_addsub_core.sv
module sat_addsub_core
    import satarith_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_sub,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             sat_clear,
    output logic [WIDTH-1:0] sum_out,
    output logic             flag_z,
    output logic             flag_s,
    output logic             flag_c,
    output logic             flag_v,
    output logic             flag_sat
);
    logic [WIDTH-1:0] raw_sum;
    logic             raw_carry;
    logic             raw_ovf;
    logic             clamp_zero;
    logic             clamp_sign;
    alu_flags_t       next_flags;
    status_t          status;

    sat_raw_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i     (opnd_a),
        .b_i     (opnd_b),
        .sub_i   (op_sub),
        .raw_o   (raw_sum),
        .carry_o (raw_carry),
        .ovf_o   (raw_ovf)
    );

    sat_clamp #(.WIDTH(WIDTH)) u_clamp (
        .raw_i  (raw_sum),
        .ovf_i  (raw_ovf),
        .res_o  (sum_out),
        .zero_o (clamp_zero),
        .sign_o (clamp_sign)
    );

    always_comb begin
        next_flags.zero  = clamp_zero;
        next_flags.sign  = clamp_sign;
        next_flags.carry = raw_carry;
        next_flags.ovf   = raw_ovf;
    end

    sat_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_i    (op_valid),
        .clr_i    (sat_clear),
        .flags_i  (next_flags),
        .status_o (status)
    );

    assign flag_z   = status.flags.zero;
    assign flag_s   = status.flags.sign;
    assign flag_c   = status.flags.carry;
    assign flag_v   = status.flags.ovf;
    assign flag_sat = status.sticky;
endmodule

// File: rtl/sat_addsub_chk.sv
module sat_addsub_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             sat_clear,
    input logic [WIDTH-1:0] sum_out,
    input logic             flag_z,
    input logic             flag_s,
    input logic             flag_c,
    input logic             flag_v,
    input logic             flag_sat
);
    localparam logic [WIDTH-1:0] POS_MAX = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] NEG_MIN = {1'b1, {(WIDTH-1){1'b0}}};

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && sum_out != POS_MAX && sum_out != NEG_MIN) |=> !flag_v);

    // R5
    zero_tracks_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (flag_z == ($past(sum_out) == '0)));

    // R5
    sign_tracks_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (flag_s == $past(sum_out[WIDTH-1])));

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable({flag_z, flag_s, flag_c, flag_v}));

    // R9
    sticky_follows_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (!flag_v || flag_sat));

    // R10
    sticky_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_sat) |-> $past(sat_clear));

    // R10
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clear && !op_valid) |=> !flag_sat);
endmodule

bind sat_addsub_core sat_addsub_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .sat_clear (sat_clear),
    .sum_out   (sum_out),
    .flag_z    (flag_z),
    .flag_s    (flag_s),
    .flag_c    (flag_c),
    .flag_v    (flag_v),
    .flag_sat  (flag_sat)
);

// File: tb/sat_addsub_core_test.sv
module sat_addsub_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int WW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic          n_valid = 0, n_sub = 0, n_clr = 0;
    logic [NW-1:0] n_a = '0, n_b = '0;
    logic [NW-1:0] n_sum;
    logic          n_z, n_s, n_c, n_v, n_sat;

    logic          w_valid = 0, w_sub = 0, w_clr = 0;
    logic [WW-1:0] w_a = '0, w_b = '0;
    logic [WW-1:0] w_sum;
    logic          w_z, w_s, w_c, w_v, w_sat;

    int checks = 0;
    int errors = 0;
    bit n_sticky = 0;
    bit w_sticky = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_addsub_core #(.WIDTH(NW)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(n_valid), .op_sub(n_sub),
        .opnd_a(n_a), .opnd_b(n_b), .sat_clear(n_clr), .sum_out(n_sum),
        .flag_z(n_z), .flag_s(n_s), .flag_c(n_c), .flag_v(n_v), .flag_sat(n_sat)
    );

    sat_addsub_core #(.WIDTH(WW)) uut_wide (
        .clk(clk), .rst_n(rst_n), .op_valid(w_valid), .op_sub(w_sub),
        .opnd_a(w_a), .opnd_b(w_b), .sat_clear(w_clr), .sum_out(w_sum),
        .flag_z(w_z), .flag_s(w_s), .flag_c(w_c), .flag_v(w_v), .flag_sat(w_sat)
    );

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Arithmetic reference from the requirements
    task automatic model(input longint ua, input longint ub, input bit sub, input int w,
                         output longint res, output bit z, output bit s,
                         output bit c, output bit v);
        longint half, full, sa, sb, exact;
        half = longint'(1) <<< (w - 1);
        full = half * 2;
        sa = (ua >= half) ? ua - full : ua;
        sb = (ub >= half) ? ub - full : ub;
        exact = sub ? sa - sb : sa + sb;
        v = 0;
        if (exact > half - 1) begin
            res = half - 1; v = 1;
        end else if (exact < -half) begin
            res = half; v = 1;
        end else begin
            res = (exact < 0) ? exact + full : exact;
        end
        z = (res == 0);
        s = (res >= half);
        c = sub ? (ua < ub) : (ua + ub >= full);
    endtask

    task automatic narrow_op(input int a, input int b, input bit sub, input bit clr);
        longint er; bit ez, es, ec, ev;
        model(longint'(a), longint'(b), sub, NW, er, ez, es, ec, ev);
        @(negedge clk);
        n_a = NW'(a); n_b = NW'(b); n_sub = sub; n_clr = clr; n_valid = 1;
        #1;
        if (ev) chk(n_sum == NW'(er), er == 7 ? "R3 clamp" : "R4 clamp", longint'(n_sum), er);
        else    chk(n_sum == NW'(er), "R1 sum", longint'(n_sum), er);
        @(posedge clk); #1;
        if (clr) n_sticky = 0;
        if (ev) n_sticky = 1;
        chk(n_v == ev, "R2 overflow", longint'(n_v), longint'(ev));
        chk(n_z == ez && n_s == es, "R5 zero/sign", longint'({n_z, n_s}), longint'({ez, es}));
        chk(n_c == ec, sub ? "R7 borrow" : "R6 carry", longint'(n_c), longint'(ec));
        chk(n_sat == n_sticky, "R9 sticky", longint'(n_sat), longint'(n_sticky));
        n_valid = 0; n_clr = 0;
    endtask

    task automatic wide_op(input logic [WW-1:0] a, input logic [WW-1:0] b, input bit sub);
        longint er; bit ez, es, ec, ev;
        model(longint'(a), longint'(b), sub, WW, er, ez, es, ec, ev);
        @(negedge clk);
        w_a = a; w_b = b; w_sub = sub; w_valid = 1;
        #1;
        chk(w_sum == WW'(er), "R3 R4 wide result", longint'(w_sum), er);
        @(posedge clk); #1;
        if (ev) w_sticky = 1;
        chk({w_z, w_s, w_c, w_v} == {ez, es, ec, ev}, "R2 R5 R6 R7 wide flags",
            longint'({w_z, w_s, w_c, w_v}), longint'({ez, es, ec, ev}));
        chk(w_sat == w_sticky, "R9 wide sticky", longint'(w_sat), longint'(w_sticky));
        w_valid = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [3:0] held;
        // R11 reset state
        repeat (3) @(posedge clk);
        #1;
        chk({n_z, n_s, n_c, n_v, n_sat} == 5'b0, "R11 reset", longint'({n_z, n_s, n_c, n_v, n_sat}), 0);
        chk({w_z, w_s, w_c, w_v, w_sat} == 5'b0, "R11 reset wide", longint'({w_z, w_s, w_c, w_v, w_sat}), 0);
        @(negedge clk);
        rst_n = 1;

        // Exhaustive sweep, clears interleaved whenever b is zero
        for (int sub = 0; sub < 2; sub++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    narrow_op(a, b, sub[0], b == 0);

        // R10: clear and overflow on the same edge, set wins
        narrow_op(7, 1, 0, 1);
        chk(n_sat == 1, "R10 set priority", longint'(n_sat), 1);
        // R10: clear alone
        @(negedge clk); n_clr = 1;
        @(posedge clk); #1; n_sticky = 0;
        chk(n_sat == 0, "R10 clear", longint'(n_sat), 0);
        @(negedge clk); n_clr = 0;
        // R9: non-overflowing op leaves cleared sticky at zero
        narrow_op(2, 3, 0, 0);
        chk(n_sat == 0, "R9 no set", longint'(n_sat), 0);

        // R8: operands change with valid low, flags hold
        narrow_op(8, 8, 0, 0);
        held = {n_z, n_s, n_c, n_v};
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            n_a = 4'(k + 1); n_b = 4'(k); n_sub = k[0]; n_valid = 0;
            @(posedge clk); #1;
            chk({n_z, n_s, n_c, n_v} == held, "R8 hold", longint'({n_z, n_s, n_c, n_v}), longint'(held));
            chk(n_sat == 1, "R8 sticky hold", longint'(n_sat), 1);
        end

        // Directed wide cases at the extremes
        wide_op(32'h0000_0005, 32'h0000_0003, 1'b1);
        wide_op(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
        wide_op(32'h8000_0000, 32'h0000_0001, 1'b1);
        wide_op(32'h8000_0000, 32'h8000_0000, 1'b0);
        wide_op(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
        wide_op(32'h0000_0000, 32'h8000_0000, 1'b1);
        wide_op(32'h8000_0000, 32'h7FFF_FFFF, 1'b1);
        wide_op(32'h1234_5678, 32'h1234_5678, 1'b1);

        report();
    end
endmodule